// File: doc/BRIEF.md
# Path-Set Input Demultiplexer with Early Ejection

This block is the receive side of one input link of a mesh router whose switching is split into a row half (east-west) and a column half (north-south). Every head flit arrives with its route for this hop already computed by the previous router. The demultiplexer reads that route class and places the packet in a virtual channel (VC) of the path set that serves its direction. It is a first switching step: flits that keep moving in X, keep moving in Y, turn from one dimension to the other, or are injected toward X or Y each end up in a queue of their own kind. A packet addressed to the local processing element never enters a queue. It leaves on the ejection port one cycle after it arrives, so it skips switch allocation and crossbar traversal.

There are twelve VC slots: four path sets of three slots, each slot a FIFO of `DEPTH` flits. Slots 0-5 are the row half and slots 6-11 the column half. A static mode input chooses how the slots are labelled (dimension-order XY, alternating XY-YX, or adaptive). The modes that need fewer turn channels give their spare slots to the straight-through class. The upstream router splits its traffic over `LANES` lanes and keeps at most `DEPTH` flits in flight per lane. The block returns one credit per flit to the lane that sent it, whether the flit was dequeued by the switch stage or ejected. Switch and VC arbitration and route computation are outside this block.

Top module: `pathset_demux`

## Requirements
- R1: During and right after reset no VC slot reports a flit, the ejection port is idle and every lane's credit count is 0.
- R2: A head flit (kind 1 = head, 3 = head+tail; kind 0 = body, 2 = tail) whose route class is 0 (X straight), 1 (Y straight), 2 (X-to-Y turn), 3 (Y-to-X turn), 4 (inject toward X) or 5 (inject toward Y) claims the lowest-numbered free slot labelled with that class. It shows on that slot's outputs after the next rising edge.
- R3: Slot labels by mode (mode 0 = XY, 1 = XY-YX, 2 = adaptive; 3 acts as XY). Slots 0, 3 and 4 are X straight. Slot 1 is X straight in XY and Y-to-X turn otherwise. Slot 2 is inject-X. Slot 5 is Y-to-X turn in adaptive and X straight otherwise. Slots 6 and 9 are Y straight. Slots 7 and 10 are X-to-Y turn. Slot 8 is inject-Y. Slot 11 is X-to-Y turn in adaptive and Y straight otherwise.
- R4: A non-ejecting head flit with no free slot of its class sees `in_ready` low and is not taken. Body and tail flits are always taken.
- R5: Body and tail flits on a lane go to the slot (or the ejection port) that the lane's last head flit chose, and they leave each slot in arrival order.
- R6: A slot becomes free in the cycle after a flit of kind 2 or 3 is dequeued from it, and it can then be claimed again.
- R7: A head flit with route class 6 or 7 and the body and tail flits behind it appear on `ej_*` exactly one cycle after acceptance, and they never enter a slot.
- R8: For each dequeued or ejected flit, the credit count of the flit's lane in the cycle after is one higher. The counts add up when several flits of one lane leave together.
- R9: A dequeue request on an empty slot changes nothing and returns no credit.
- R10: A slot holds `DEPTH` flits of one packet and gives them back in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Slot-label mode, held static |
| in_valid | input | 1 | Incoming flit present |
| in_lane | input | LW | Upstream lane of the flit |
| in_kind | input | 2 | 0 body, 1 head, 2 tail, 3 head+tail |
| in_route | input | 3 | Route class of a head flit |
| in_data | input | 16 | Flit payload |
| in_ready | output | 1 | Flit is taken this cycle |
| vc_deq | input | 12 | Per-slot dequeue request |
| vc_valid | output | 12 | Per-slot front flit present |
| vc_flit | output | 12*18 | Per-slot front flit {kind, data} |
| ej_valid | output | 1 | Ejected flit present |
| ej_lane | output | LW | Lane of the ejected flit |
| ej_kind | output | 2 | Kind of the ejected flit |
| ej_data | output | 16 | Payload of the ejected flit |
| crd_cnt | output | LANES*4 | Per-lane credits returned this cycle |

## Verification
Directed sequences fill the slots of one class in each mode. The occupied-slot mask then tells the three label layouts apart, and the next head of that class shows whether stalling starts at the right count. A five-flit packet that is then drained separates correct order and release from early or late slot freeing. An ejected packet tells the bypass path apart from slot allocation. Random mixed traffic on all lanes, with random dequeue masks that include empty slots, exercises credit summing when several flits of one lane leave in the same cycle, together with lane-to-slot tracking under interleaving.

// File: rtl/pds_pkg.sv
`timescale 1ns/1ps
package pds_pkg;
    localparam int N_SETS   = 4;
    localparam int SET_VCS  = 3;
    localparam int N_VC     = N_SETS * SET_VCS;
    localparam int VC_DEPTH = 5;
    localparam int N_LANES  = 3;
    localparam int FLIT_DW  = 16;

    typedef enum logic [1:0] {
        K_BODY   = 2'd0,
        K_HEAD   = 2'd1,
        K_TAIL   = 2'd2,
        K_SINGLE = 2'd3
    } kind_e;

    typedef enum logic [2:0] {
        R_XSTR  = 3'd0,
        R_YSTR  = 3'd1,
        R_XTOY  = 3'd2,
        R_YTOX  = 3'd3,
        R_INJX  = 3'd4,
        R_INJY  = 3'd5,
        R_LOCAL = 3'd6,
        R_LOC2  = 3'd7
    } route_e;

    typedef enum logic [1:0] {
        M_XY    = 2'd0,
        M_XYYX  = 2'd1,
        M_ADAPT = 2'd2,
        M_RSVD  = 2'd3
    } mode_e;

    typedef struct packed {
        kind_e               kind;
        logic [FLIT_DW-1:0]  data;
    } entry_t;

    localparam int ENTRY_W = $bits(entry_t);

    function automatic logic kind_is_head(logic [1:0] k);
        return k[0];
    endfunction

    function automatic logic kind_is_tail(logic [1:0] k);
        return k[1];
    endfunction

    function automatic logic route_is_local(logic [2:0] r);
        return r[2] & r[1];
    endfunction

    // Label of one slot given its path set and position in that set.
    function automatic route_e slot_class(mode_e m, int unsigned set, int unsigned pos);
        route_e c;
        c = R_LOCAL;
        case (set)
            0: case (pos)
                   0: c = R_XSTR;
                   1: c = (m == M_XY || m == M_RSVD) ? R_XSTR : R_YTOX;
                   default: c = R_INJX;
               endcase
            1: case (pos)
                   0, 1: c = R_XSTR;
                   default: c = (m == M_ADAPT) ? R_YTOX : R_XSTR;
               endcase
            2: case (pos)
                   0: c = R_YSTR;
                   1: c = R_XTOY;
                   default: c = R_INJY;
               endcase
            3: case (pos)
                   0: c = R_YSTR;
                   1: c = R_XTOY;
                   default: c = (m == M_ADAPT) ? R_XTOY : R_YSTR;
               endcase
            default: c = R_LOCAL;
        endcase
        return c;
    endfunction
endpackage

// File: rtl/pds_vc_fifo.sv
`timescale 1ns/1ps
module pds_vc_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         valid,
    output logic         full
);
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);

    logic [W-1:0]    mem [DEPTH];
    logic [AW-1:0]   wp, rp;
    logic [CNTW-1:0] cnt;
    logic            do_push, do_pop;

    assign valid   = (cnt != '0);
    assign full    = (cnt == CNTW'(DEPTH));
    assign do_pop  = pop & valid;
    assign do_push = push & ~full;
    assign rdata   = mem[rp];

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= bump(wp);
            if (do_pop)  rp <= bump(rp);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + CNTW'(1);
                2'b01:   cnt <= cnt - CNTW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end
endmodule

// File: rtl/pds_lowest_pick.sv
`timescale 1ns/1ps
module pds_lowest_pick #(
    parameter int N  = 12,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  cand,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) idx = IW'(i);
        end
        found = |cand;
    end
endmodule

// File: rtl/pds_credit_sum.sv
`timescale 1ns/1ps
module pds_credit_sum #(
    parameter int NVC   = 12,
    parameter int LANES = 3,
    parameter int LW    = 2,
    parameter int CW    = 4
) (
    input  logic [NVC-1:0]         pop_fire,
    input  logic [NVC-1:0][LW-1:0] slot_lane,
    input  logic                   ej_fire,
    input  logic [LW-1:0]          ej_lane,
    output logic [LANES*CW-1:0]    cnt
);
    always_comb begin
        cnt = '0;
        for (int l = 0; l < LANES; l++) begin
            logic [CW-1:0] acc;
            acc = '0;
            for (int s = 0; s < NVC; s++) begin
                if (pop_fire[s] && slot_lane[s] == LW'(l)) acc = acc + CW'(1);
            end
            if (ej_fire && ej_lane == LW'(l)) acc = acc + CW'(1);
            cnt[l*CW +: CW] = acc;
        end
    end
endmodule

// File: rtl/pathset_demux.sv
`timescale 1ns/1ps
module pathset_demux
    import pds_pkg::*;
#(
    parameter  int DEPTH = VC_DEPTH,
    parameter  int LANES = N_LANES,
    localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int CW    = $clog2(N_VC + 2),
    localparam int IW    = $clog2(N_VC)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [1:0]                mode,
    input  logic                      in_valid,
    input  logic [LW-1:0]             in_lane,
    input  logic [1:0]                in_kind,
    input  logic [2:0]                in_route,
    input  logic [FLIT_DW-1:0]        in_data,
    output logic                      in_ready,
    input  logic [N_VC-1:0]           vc_deq,
    output logic [N_VC-1:0]           vc_valid,
    output logic [N_VC*ENTRY_W-1:0]   vc_flit,
    output logic                      ej_valid,
    output logic [LW-1:0]             ej_lane,
    output logic [1:0]                ej_kind,
    output logic [FLIT_DW-1:0]        ej_data,
    output logic [LANES*CW-1:0]       crd_cnt
);
    // Per-lane packet tracking
    logic [LANES-1:0]          lane_act, lane_ej;
    logic [LANES-1:0][IW-1:0]  lane_slot;

    // Per-slot state
    logic [N_VC-1:0]           slot_busy;
    logic [N_VC-1:0][LW-1:0]   slot_lane;
    route_e                    slot_cls [N_VC];
    logic [N_VC-1:0]           cand, fifo_push, fifo_full, fifo_valid, pop_fire, slot_free;
    logic [ENTRY_W-1:0]        rd_raw [N_VC];

    logic          lane_ok, is_head, is_tail, local_rt;
    logic          found, to_ej, to_vc, acc, ej_fire;
    logic [IW-1:0] pick_idx, tgt;
    logic [LANES*CW-1:0] crd_next;
    entry_t        wentry;

    assign lane_ok  = ({1'b0, in_lane} < (LW+1)'(LANES));
    assign is_head  = kind_is_head(in_kind);
    assign is_tail  = kind_is_tail(in_kind);
    assign local_rt = route_is_local(in_route);
    assign wentry   = '{kind: kind_e'(in_kind), data: in_data};

    pds_lowest_pick #(.N(N_VC), .IW(IW)) u_pick (
        .cand  (cand),
        .found (found),
        .idx   (pick_idx)
    );

    // Steering decision
    always_comb begin
        if (is_head) begin
            to_ej    = local_rt;
            to_vc    = !local_rt && found;
            tgt      = pick_idx;
            in_ready = local_rt || found;
        end else begin
            to_ej    = lane_act[in_lane] && lane_ej[in_lane];
            to_vc    = lane_act[in_lane] && !lane_ej[in_lane];
            tgt      = lane_slot[in_lane];
            in_ready = 1'b1;
        end
    end

    assign acc     = in_valid && in_ready && lane_ok;
    assign ej_fire = acc && to_ej;

    for (genvar s = 0; s < N_VC; s++) begin : g_slot
        assign slot_cls[s]  = slot_class(mode_e'(mode), s / SET_VCS, s % SET_VCS);
        assign cand[s]      = !slot_busy[s] && (slot_cls[s] == route_e'(in_route));
        assign fifo_push[s] = acc && to_vc && (tgt == IW'(s));

        pds_vc_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
            .clk   (clk),
            .rst   (rst),
            .push  (fifo_push[s]),
            .wdata (wentry),
            .pop   (vc_deq[s]),
            .rdata (rd_raw[s]),
            .valid (fifo_valid[s]),
            .full  (fifo_full[s])
        );

        assign pop_fire[s]                  = vc_deq[s] && fifo_valid[s];
        assign slot_free[s]                 = pop_fire[s] && rd_raw[s][ENTRY_W-1];
        assign vc_valid[s]                  = fifo_valid[s];
        assign vc_flit[s*ENTRY_W +: ENTRY_W] = rd_raw[s];
    end

    // Slot ownership
    always_ff @(posedge clk) begin
        if (rst) begin
            slot_busy <= '0;
            slot_lane <= '0;
        end else begin
            for (int s = 0; s < N_VC; s++) begin
                if (fifo_push[s] && is_head) begin
                    slot_busy[s] <= 1'b1;
                    slot_lane[s] <= in_lane;
                end else if (slot_free[s]) begin
                    slot_busy[s] <= 1'b0;
                end
            end
        end
    end

    // Lane bookkeeping follows head and tail flits
    always_ff @(posedge clk) begin
        if (rst) begin
            lane_act  <= '0;
            lane_ej   <= '0;
            lane_slot <= '0;
        end else if (acc) begin
            if (is_head) begin
                lane_act[in_lane]  <= !is_tail;
                lane_ej[in_lane]   <= local_rt;
                lane_slot[in_lane] <= pick_idx;
            end else if (is_tail) begin
                lane_act[in_lane]  <= 1'b0;
            end
        end
    end

    // Early ejection register
    always_ff @(posedge clk) begin
        if (rst) begin
            ej_valid <= 1'b0;
            ej_lane  <= '0;
            ej_kind  <= '0;
            ej_data  <= '0;
        end else begin
            ej_valid <= ej_fire;
            if (ej_fire) begin
                ej_lane <= in_lane;
                ej_kind <= in_kind;
                ej_data <= in_data;
            end
        end
    end

    pds_credit_sum #(.NVC(N_VC), .LANES(LANES), .LW(LW), .CW(CW)) u_crd (
        .pop_fire  (pop_fire),
        .slot_lane (slot_lane),
        .ej_fire   (ej_fire),
        .ej_lane   (in_lane),
        .cnt       (crd_next)
    );

    always_ff @(posedge clk) begin
        if (rst) crd_cnt <= '0;
        else     crd_cnt <= crd_next;
    end
endmodule

// File: rtl/pds_checker.sv
`timescale 1ns/1ps
module pds_checker #(
    parameter int NVC   = 12,
    parameter int LANES = 3,
    parameter int LW    = 2,
    parameter int CW    = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic               in_ready,
    input logic [1:0]         in_kind,
    input logic [2:0]         in_route,
    input logic               ej_valid,
    input logic [LW-1:0]      ej_lane,
    input logic [LANES*CW-1:0] crd_cnt,
    input logic [NVC-1:0]     vc_valid,
    input logic [NVC-1:0]     slot_busy,
    input logic [NVC-1:0]     fifo_push,
    input logic [NVC-1:0]     fifo_full
);
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
        (fifo_push & fifo_full) == '0);

    p_body_taken_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_kind[0]) |-> in_ready);

    p_eject_next_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_kind[0] && in_route[2] && in_route[1]) |=> ej_valid);

    p_eject_credit_r8: assert property (@(posedge clk) disable iff (rst)
        ej_valid |-> (crd_cnt[ej_lane*CW +: CW] != '0));

    p_free_is_empty_r6: assert property (@(posedge clk) disable iff (rst)
        (vc_valid & ~slot_busy) == '0);
endmodule

bind pathset_demux pds_checker #(
    .NVC(pds_pkg::N_VC), .LANES(LANES), .LW(LW), .CW(CW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_kind   (in_kind),
    .in_route  (in_route),
    .ej_valid  (ej_valid),
    .ej_lane   (ej_lane),
    .crd_cnt   (crd_cnt),
    .vc_valid  (vc_valid),
    .slot_busy (slot_busy),
    .fifo_push (fifo_push),
    .fifo_full (fifo_full)
);

// File: tb/tb_pathset_demux.sv
`timescale 1ns/1ps
module tb_pathset_demux;
    import pds_pkg::*;

    localparam int NVC = N_VC;
    localparam int L   = N_LANES;
    localparam int LW  = 2;
    localparam int CW  = 4;
    localparam int EW  = ENTRY_W;

    logic                 clk, rst;
    logic [1:0]           mode;
    logic                 in_valid;
    logic [LW-1:0]        in_lane;
    logic [1:0]           in_kind;
    logic [2:0]           in_route;
    logic [FLIT_DW-1:0]   in_data;
    logic                 in_ready;
    logic [NVC-1:0]       vc_deq, vc_valid;
    logic [NVC*EW-1:0]    vc_flit;
    logic                 ej_valid;
    logic [LW-1:0]        ej_lane;
    logic [1:0]           ej_kind;
    logic [FLIT_DW-1:0]   ej_data;
    logic [L*CW-1:0]      crd_cnt;

    pathset_demux dut (.*);

    initial clk = 1'b0;
    always #5 clk = ~clk;

    int errs = 0, checks = 0;

    // Reference state
    logic [EW-1:0] mq [NVC][$];
    bit   m_busy [NVC];
    int   m_slane [NVC];
    bit   m_act [L];
    bit   m_ej [L];
    int   m_slot [L];
    bit   e_ejv;
    int   e_ejl;
    logic [1:0] e_ejk;
    logic [FLIT_DW-1:0] e_ejd;
    int   e_crd [L];
    int   lane_out [L];
    mode_e cur_mode;

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Slot labels as listed in R3
    function automatic route_e lbl(mode_e m, int s);
        case (s)
            0, 3, 4: return R_XSTR;
            1:       return (m == M_XY) ? R_XSTR : R_YTOX;
            2:       return R_INJX;
            5:       return (m == M_ADAPT) ? R_YTOX : R_XSTR;
            6, 9:    return R_YSTR;
            7, 10:   return R_XTOY;
            8:       return R_INJY;
            default: return (m == M_ADAPT) ? R_XTOY : R_YSTR;
        endcase
    endfunction

    function automatic int m_pick(route_e r);
        for (int s = 0; s < NVC; s++)
            if (!m_busy[s] && lbl(cur_mode, s) == r) return s;
        return -1;
    endfunction

    function automatic bit class_exists(route_e r);
        for (int s = 0; s < NVC; s++)
            if (lbl(cur_mode, s) == r) return 1'b1;
        return 1'b0;
    endfunction

    task automatic model_step(bit v, int lane, logic [1:0] k, logic [2:0] r,
                              logic [FLIT_DW-1:0] d, logic [NVC-1:0] dq, bit rdy, int pick);
        logic [EW-1:0] ent;
        bit eject_it, push_it;
        int slot;
        for (int l = 0; l < L; l++) e_crd[l] = 0;
        e_ejv = 1'b0;
        for (int s = 0; s < NVC; s++) begin
            if (dq[s] && mq[s].size() > 0) begin
                ent = mq[s].pop_front();
                e_crd[m_slane[s]]++;
                if (ent[EW-1]) m_busy[s] = 1'b0;
            end
        end
        eject_it = 1'b0; push_it = 1'b0; slot = 0;
        if (v && rdy) begin
            if (k[0]) begin
                m_act[lane] = !k[1];
                if (r >= 3'd6) begin
                    eject_it = 1'b1; m_ej[lane] = 1'b1;
                end else begin
                    push_it = 1'b1; slot = pick; m_ej[lane] = 1'b0;
                    m_slot[lane] = pick; m_busy[pick] = 1'b1; m_slane[pick] = lane;
                end
            end else if (m_act[lane]) begin
                if (m_ej[lane]) eject_it = 1'b1;
                else begin push_it = 1'b1; slot = m_slot[lane]; end
                if (k[1]) m_act[lane] = 1'b0;
            end
        end
        if (push_it) begin
            mq[slot].push_back({k, d});
            lane_out[lane]++;
        end
        if (eject_it) begin
            e_ejv = 1'b1; e_ejl = lane; e_ejk = k; e_ejd = d;
            e_crd[lane]++;
            lane_out[lane]++;
        end
        for (int l = 0; l < L; l++) lane_out[l] -= e_crd[l];
    endtask

    task automatic compare_outputs();
        logic [NVC-1:0] ev;
        for (int s = 0; s < NVC; s++) ev[s] = (mq[s].size() > 0);
        chk(vc_valid == ev, "R2 vc_valid", 32'(vc_valid), 32'(ev));
        for (int s = 0; s < NVC; s++)
            if (ev[s]) chk(vc_flit[s*EW +: EW] == mq[s][0], "R5 front flit",
                           32'(vc_flit[s*EW +: EW]), 32'(mq[s][0]));
        chk(ej_valid == e_ejv, "R7 ej_valid", 32'(ej_valid), 32'(e_ejv));
        if (e_ejv)
            chk({ej_lane, ej_kind, ej_data} == {LW'(e_ejl), e_ejk, e_ejd}, "R7 ej flit",
                32'({ej_lane, ej_kind, ej_data}), 32'({LW'(e_ejl), e_ejk, e_ejd}));
        for (int l = 0; l < L; l++)
            chk(crd_cnt[l*CW +: CW] == CW'(e_crd[l]), "R8 credit",
                32'(crd_cnt[l*CW +: CW]), 32'(e_crd[l]));
    endtask

    task automatic step(bit v, int lane, logic [1:0] k, logic [2:0] r,
                        logic [FLIT_DW-1:0] d, logic [NVC-1:0] dq, output bit acc);
        bit rdy;
        int pick;
        @(negedge clk);
        compare_outputs();
        in_valid = v; in_lane = LW'(lane); in_kind = k; in_route = r; in_data = d;
        vc_deq = dq;
        #1;
        pick = -1;
        if (!k[0] || r >= 3'd6) rdy = 1'b1;
        else begin pick = m_pick(route_e'(r)); rdy = (pick >= 0); end
        if (v) chk(in_ready == rdy, "R4 in_ready", 32'(in_ready), 32'(rdy));
        acc = v && rdy;
        model_step(v, lane, k, r, d, dq, rdy, pick);
    endtask

    task automatic send(int lane, logic [1:0] k, logic [2:0] r, logic [FLIT_DW-1:0] d, output bit acc);
        step(1'b1, lane, k, r, d, '0, acc);
    endtask

    task automatic idle(logic [NVC-1:0] dq);
        bit a;
        step(1'b0, 0, 2'd0, 3'd0, '0, dq, a);
    endtask

    task automatic do_reset(mode_e m);
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; vc_deq = '0; mode = m; cur_mode = m;
        for (int s = 0; s < NVC; s++) begin mq[s].delete(); m_busy[s] = 0; m_slane[s] = 0; end
        for (int l = 0; l < L; l++) begin m_act[l] = 0; m_ej[l] = 0; m_slot[l] = 0; e_crd[l] = 0; lane_out[l] = 0; end
        e_ejv = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(vc_valid == '0 && !ej_valid && crd_cnt == '0, "R1 reset state",
            32'({vc_valid, ej_valid}), 32'h0);
        rst = 1'b0;
    endtask

    // Random traffic state per lane
    int   r_len [L], r_idx [L];
    logic [2:0] r_rt [L];
    logic [1:0] r_kind [L];
    logic [FLIT_DW-1:0] r_dat [L];
    bit   r_has [L];

    task automatic run_random(int n);
        bit acc;
        for (int l = 0; l < L; l++) begin r_len[l] = 0; r_idx[l] = 0; r_has[l] = 0; end
        for (int i = 0; i < n; i++) begin
            int l;
            bit v;
            logic [NVC-1:0] dq;
            l = int'($urandom % L);
            v = 1'b0;
            if (!r_has[l] && lane_out[l] < VC_DEPTH) begin
                if (r_idx[l] >= r_len[l]) begin
                    r_len[l] = 1 + int'($urandom % 4);
                    r_idx[l] = 0;
                    r_rt[l]  = 3'($urandom % 8);
                    if (r_rt[l] < 3'd6 && !class_exists(route_e'(r_rt[l]))) r_rt[l] = 3'd1;
                end
                if (r_len[l] == 1)              r_kind[l] = 2'd3;
                else if (r_idx[l] == 0)         r_kind[l] = 2'd1;
                else if (r_idx[l] == r_len[l]-1) r_kind[l] = 2'd2;
                else                            r_kind[l] = 2'd0;
                r_dat[l] = 16'($urandom);
                r_has[l] = 1'b1;
            end
            if (r_has[l] && lane_out[l] < VC_DEPTH) v = 1'b1;
            dq = NVC'($urandom & $urandom);
            step(v, l, r_kind[l], r_rt[l], r_dat[l], dq, acc);
            if (acc) begin r_has[l] = 1'b0; r_idx[l]++; end
        end
        repeat (12) idle('1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL R1 watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks + 1);
        $finish;
    end

    initial begin : main
        bit a;
        void'($urandom(32'h1D5E_7A11));
        rst = 1'b1; in_valid = 0; in_lane = 0; in_kind = 0; in_route = 0; in_data = 0;
        vc_deq = '0; mode = 2'd0;

        // XY layout and stall
        do_reset(M_XY);
        for (int i = 0; i < 5; i++) send(i % 3, 2'd3, 3'd0, 16'(100 + i), a);
        idle('0);
        chk(vc_valid == 12'h03B, "R3 XY straight-X slots", 32'(vc_valid), 32'h03B);
        send(2, 2'd3, 3'd0, 16'd105, a);
        chk(a == 1'b0, "R4 head stalls with class full", 32'(a), 32'h0);
        idle(12'h001);
        idle('0);
        chk(crd_cnt[0 +: CW] == CW'(1), "R8 dequeue credit lane0", 32'(crd_cnt[0 +: CW]), 32'h1);
        idle(12'h004);
        idle('0);
        chk(crd_cnt == '0 && vc_valid == 12'h03A, "R9 dequeue of empty slot",
            32'({crd_cnt, vc_valid}), 32'h03A);

        // Depth, order, release and reuse
        do_reset(M_XY);
        send(1, 2'd1, 3'd1, 16'd200, a);
        for (int i = 1; i < 4; i++) send(1, 2'd0, 3'd0, 16'(200 + i), a);
        send(1, 2'd2, 3'd0, 16'd204, a);
        idle('0);
        chk(vc_valid == 12'h040, "R10 five flits in slot 6", 32'(vc_valid), 32'h040);
        repeat (5) idle(12'h040);
        idle('0);
        chk(vc_valid == '0, "R6 slot empty after tail", 32'(vc_valid), 32'h0);
        send(0, 2'd3, 3'd1, 16'd210, a);
        idle('0);
        chk(vc_valid == 12'h040, "R6 freed slot reused", 32'(vc_valid), 32'h040);

        // Early ejection
        send(2, 2'd1, 3'd6, 16'd300, a);
        send(2, 2'd0, 3'd0, 16'd301, a);
        send(2, 2'd2, 3'd0, 16'd302, a);
        idle('0);
        chk(vc_valid == 12'h040, "R7 ejected packet skips slots", 32'(vc_valid), 32'h040);
        run_random(3000);

        // Adaptive layout
        do_reset(M_ADAPT);
        for (int i = 0; i < 3; i++) send(i, 2'd3, 3'd2, 16'(400 + i), a);
        idle('0);
        chk(vc_valid == 12'hC80, "R3 adaptive turn-to-Y slots", 32'(vc_valid), 32'hC80);
        send(0, 2'd3, 3'd2, 16'd403, a);
        chk(a == 1'b0, "R4 adaptive stall", 32'(a), 32'h0);
        send(1, 2'd3, 3'd3, 16'd410, a);
        send(2, 2'd3, 3'd3, 16'd411, a);
        idle('0);
        chk(vc_valid == 12'hCA2, "R3 adaptive turn-to-X slots", 32'(vc_valid), 32'hCA2);
        run_random(3000);

        // XY-YX layout
        do_reset(M_XYYX);
        send(0, 2'd3, 3'd3, 16'd500, a);
        send(1, 2'd3, 3'd3, 16'd501, a);
        chk(a == 1'b0, "R4 single turn-to-X slot", 32'(a), 32'h0);
        send(2, 2'd3, 3'd0, 16'd502, a);
        idle('0);
        chk(vc_valid == 12'h003, "R3 XY-YX slot labels", 32'(vc_valid), 32'h003);
        run_random(3000);

        idle('0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule